// File: doc/BRIEF.md
# Multichannel Time-Slot Mask Demultiplexer

This block sits behind one port of an upstream time-slot router. The router hands it only the slots that belong to this port, one octet per strobe. The block shares those routed slots among a set of logical channels. Two masks per channel decide which routed slots that channel owns, one for receive and one for transmit. Bit n of a mask stands for the n-th routed slot since the last frame start, not for the absolute slot in the line frame. Disjoint masks interleave channels freely. For example, with masks 0xAA and 0x55, two channels take turns slot by slot.

On receive, each strobed octet is forwarded one cycle later with the number of the owning channel and a valid pulse. On transmit, the block names the owning channel to the data sources in the same cycle as the slot strobe. It then drives the returned octet, or idle ones, one cycle later. Each channel is either transparent, where the octet passes through unchanged or with its bit order reversed, or framed. Framed data is never reversed and is tagged for an external framer.

Top module: `tdm_chan_demux`

## Requirements
- R1: While rst_ni is low, rx_valid_o, tx_valid_o, conflict_o and all underflow_o bits are 0, and tx_data_o is all ones.
- R2: The routed-slot index advances once per strobe, not per clock. It saturates at NUM_SLOTS, and slots with an index at or above NUM_SLOTS belong to no channel.
- R3: When a receive strobe hits a slot owned by a channel, the next cycle shows rx_valid_o = 1, rx_ch_o = that channel, and the octet on rx_data_o.
- R4: A received octet in a slot that no channel owns is dropped, and rx_valid_o stays 0 in the next cycle.
- R5: When several channels set the same mask bit, the lowest-numbered channel owns the slot, in both directions.
- R6: conflict_o goes to 1 and stays at 1 until reset once a strobed slot in either direction is claimed by two or more channels.
- R7: A channel with rev_i[c] = 1 and framed_i[c] = 0 has output bit i taken from input bit DATA_W-1-i, on receive and on transmit alike.
- R8: A channel with framed_i[c] = 1 is never bit-reversed, whatever rev_i[c] is, and its received octets carry rx_framed_o = 1. Transparent octets carry rx_framed_o = 0.
- R9: tx_req_o is 1 in exactly the strobe cycles whose slot has an owner, and tx_ch_o names that owner in the same cycle.
- R10: Every transmit strobe yields tx_valid_o = 1 in the next cycle. tx_data_o then carries the owner's octet (after R7), or all ones when the slot has no owner.
- R11: If the owner has tx_avail_i = 0 in its request cycle, tx_data_o is all ones in the next cycle and underflow_o[owner] is set until reset.
- R12: A strobe with the start flag sets that slot's index to 0, even in the middle of a frame. Receive and transmit keep separate indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_mask_i | input | NUM_CH*NUM_SLOTS | Receive masks, channel c at bits [c*NUM_SLOTS +: NUM_SLOTS] |
| tx_mask_i | input | NUM_CH*NUM_SLOTS | Transmit masks, same layout |
| rev_i | input | NUM_CH | Per-channel bit-order reversal (transparent only) |
| framed_i | input | NUM_CH | Per-channel framed mode |
| rx_start_i | input | 1 | This receive strobe is routed slot 0 |
| rx_strobe_i | input | 1 | Receive octet present |
| rx_data_i | input | DATA_W | Received octet |
| rx_valid_o | output | 1 | Delivered octet valid |
| rx_ch_o | output | CH_W | Destination channel |
| rx_data_o | output | DATA_W | Delivered octet |
| rx_framed_o | output | 1 | Octet belongs to a framed channel |
| tx_start_i | input | 1 | This transmit strobe is routed slot 0 |
| tx_strobe_i | input | 1 | Transmit slot now |
| tx_req_o | output | 1 | Octet requested from tx_ch_o |
| tx_ch_o | output | CH_W | Owning channel of the current transmit slot |
| tx_avail_i | input | 1 | Requested channel has an octet |
| tx_data_i | input | DATA_W | Octet from the requested channel |
| tx_valid_o | output | 1 | Transmit octet on tx_data_o |
| tx_data_o | output | DATA_W | Transmit octet or idle ones |
| conflict_o | output | 1 | Sticky multiple-claim flag |
| underflow_o | output | NUM_CH | Sticky per-channel transmit underflow |

## Verification
The bench builds the block with NUM_CH = 4, NUM_SLOTS = 8 and DATA_W = 8. With these values a whole mask is one octet, and a frame of ten strobes runs every slot, including two beyond the mask range. The sweep goes through several mask, reverse and framed patterns, from disjoint interleaved masks to overlapping and empty ones. Across these it checks every slot's owner, priority, data ordering and idle fill against a model the bench computes itself. Idle cycles between strobes and a mid-frame restart exercise the indexing rules, and a starved source exercises the sticky underflow.

// File: rtl/tcd_pkg.sv
package tcd_pkg;
  function automatic int unsigned ch_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tcd_slot_ctr.sv
module tcd_slot_ctr #(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             start_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_SLOTS);

  logic [IDX_W-1:0] cnt_q;

  assign idx_o = start_i ? '0 : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      cnt_q <= (idx_o == LIMIT) ? LIMIT : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/tcd_owner.sv
module tcd_owner #(
  parameter int unsigned NUM_CH    = 64,
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned CH_W      = 6,
  parameter int unsigned IDX_W     = 7
) (
  input  logic [NUM_CH*NUM_SLOTS-1:0] masks_i,
  input  logic [IDX_W-1:0]            idx_i,
  output logic                        hit_o,
  output logic [CH_W-1:0]             ch_o,
  output logic                        multi_o
);
  localparam int unsigned SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic              in_range;
  logic [NUM_CH-1:0] col;

  assign in_range = (idx_i < IDX_W'(NUM_SLOTS));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_col
    logic [NUM_SLOTS-1:0] row;
    assign row    = masks_i[c*NUM_SLOTS +: NUM_SLOTS];
    assign col[c] = in_range & row[idx_i[SLOT_W-1:0]];
  end

  // lowest index wins: scan from the top down
  always_comb begin
    ch_o = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (col[c]) ch_o = CH_W'(c);
    end
  end

  assign hit_o   = |col;
  assign multi_o = |(col & (col - 1'b1));
endmodule

// File: rtl/tcd_bitrev.sv
module tcd_bitrev #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  input  logic         en_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] rev;

  for (genvar i = 0; i < W; i++) begin : g_rev
    assign rev[i] = d_i[W-1-i];
  end

  assign d_o = en_i ? rev : d_i;
endmodule

// File: rtl/tdm_chan_demux.sv
module tdm_chan_demux
  import tcd_pkg::*;
#(
  parameter int unsigned NUM_CH    = 64,
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CH_W      = ch_width(NUM_CH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_CH*NUM_SLOTS-1:0] rx_mask_i,
  input  logic [NUM_CH*NUM_SLOTS-1:0] tx_mask_i,
  input  logic [NUM_CH-1:0]           rev_i,
  input  logic [NUM_CH-1:0]           framed_i,
  input  logic                        rx_start_i,
  input  logic                        rx_strobe_i,
  input  logic [DATA_W-1:0]           rx_data_i,
  output logic                        rx_valid_o,
  output logic [CH_W-1:0]             rx_ch_o,
  output logic [DATA_W-1:0]           rx_data_o,
  output logic                        rx_framed_o,
  input  logic                        tx_start_i,
  input  logic                        tx_strobe_i,
  output logic                        tx_req_o,
  output logic [CH_W-1:0]             tx_ch_o,
  input  logic                        tx_avail_i,
  input  logic [DATA_W-1:0]           tx_data_i,
  output logic                        tx_valid_o,
  output logic [DATA_W-1:0]           tx_data_o,
  output logic                        conflict_o,
  output logic [NUM_CH-1:0]           underflow_o
);
  localparam int unsigned IDX_W = $clog2(NUM_SLOTS + 1);

  logic [IDX_W-1:0]  rx_idx, tx_idx;
  logic              rx_hit, tx_hit, rx_multi, tx_multi;
  logic [CH_W-1:0]   rx_own, tx_own;
  logic              rx_rev_en, tx_rev_en;
  logic [DATA_W-1:0] rx_ord, tx_ord;

  tcd_slot_ctr #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_rx_ctr (
    .clk_i, .rst_ni, .strobe_i(rx_strobe_i), .start_i(rx_start_i), .idx_o(rx_idx)
  );
  tcd_slot_ctr #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_tx_ctr (
    .clk_i, .rst_ni, .strobe_i(tx_strobe_i), .start_i(tx_start_i), .idx_o(tx_idx)
  );

  tcd_owner #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .IDX_W(IDX_W)) u_rx_own (
    .masks_i(rx_mask_i), .idx_i(rx_idx), .hit_o(rx_hit), .ch_o(rx_own), .multi_o(rx_multi)
  );
  tcd_owner #(.NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .IDX_W(IDX_W)) u_tx_own (
    .masks_i(tx_mask_i), .idx_i(tx_idx), .hit_o(tx_hit), .ch_o(tx_own), .multi_o(tx_multi)
  );

  // reversal applies to transparent channels only
  assign rx_rev_en = rev_i[rx_own] & ~framed_i[rx_own];
  assign tx_rev_en = rev_i[tx_own] & ~framed_i[tx_own];

  tcd_bitrev #(.W(DATA_W)) u_rx_rev (.d_i(rx_data_i), .en_i(rx_rev_en), .d_o(rx_ord));
  tcd_bitrev #(.W(DATA_W)) u_tx_rev (.d_i(tx_data_i), .en_i(tx_rev_en), .d_o(tx_ord));

  assign tx_req_o = tx_strobe_i & tx_hit;
  assign tx_ch_o  = tx_own;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o  <= 1'b0;
      rx_ch_o     <= '0;
      rx_data_o   <= '0;
      rx_framed_o <= 1'b0;
    end else begin
      rx_valid_o <= rx_strobe_i & rx_hit;
      if (rx_strobe_i & rx_hit) begin
        rx_ch_o     <= rx_own;
        rx_data_o   <= rx_ord;
        rx_framed_o <= framed_i[rx_own];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_valid_o <= 1'b0;
      tx_data_o  <= '1;
    end else begin
      tx_valid_o <= tx_strobe_i;
      if (tx_strobe_i) tx_data_o <= (tx_req_o & tx_avail_i) ? tx_ord : '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conflict_o  <= 1'b0;
      underflow_o <= '0;
    end else begin
      if ((rx_strobe_i & rx_multi) | (tx_strobe_i & tx_multi)) conflict_o <= 1'b1;
      if (tx_req_o & ~tx_avail_i) underflow_o[tx_own] <= 1'b1;
    end
  end
endmodule

// File: rtl/tcd_checker.sv
module tcd_checker #(
  parameter int unsigned NUM_CH    = 64,
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned DATA_W    = 8
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [NUM_CH*NUM_SLOTS-1:0] rx_mask_i,
  input logic                        rx_strobe_i,
  input logic                        rx_valid_o,
  input logic                        tx_strobe_i,
  input logic                        tx_req_o,
  input logic                        tx_avail_i,
  input logic                        tx_valid_o,
  input logic [DATA_W-1:0]           tx_data_o,
  input logic                        conflict_o,
  input logic [NUM_CH-1:0]           underflow_o
);
  a_r3_rx_follows_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(rx_strobe_i));

  a_r4_no_owner_no_rx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_strobe_i && rx_mask_i == '0) |=> !rx_valid_o);

  a_r6_conflict_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(conflict_o) |-> conflict_o);

  a_r9_req_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_req_o |-> tx_strobe_i);

  a_r10_valid_per_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_strobe_i |=> tx_valid_o);

  a_r10_idle_unowned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_strobe_i && !tx_req_o) |=> (tx_data_o == '1));

  a_r11_underflow_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_avail_i) |=> (tx_data_o == '1 && underflow_o != '0));

  a_r11_underflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (underflow_o & $past(underflow_o)) == $past(underflow_o));
endmodule

bind tdm_chan_demux tcd_checker #(
  .NUM_CH(NUM_CH), .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/sim_tdm_chan_demux.sv
`timescale 1ns/1ps
module sim_tdm_chan_demux;
  localparam int NC = 4;
  localparam int NS = 8;
  localparam int DW = 8;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NC*NS-1:0] rxm = '0, txm = '0;
  logic [NC-1:0] rev = '0, frm = '0;
  logic rx_start_i = 0, rx_strobe_i = 0, tx_start_i = 0, tx_strobe_i = 0, tx_avail_i = 0;
  logic [DW-1:0] rx_data_i = '0, tx_data_i = '0;
  logic rx_valid_o, rx_framed_o, tx_req_o, tx_valid_o, conflict_o;
  logic [CW-1:0] rx_ch_o, tx_ch_o;
  logic [DW-1:0] rx_data_o, tx_data_o;
  logic [NC-1:0] underflow_o;

  int checks = 0, fails = 0;
  int b_rx = 0, b_tx = 0;
  bit exp_conf = 0;
  logic [NC-1:0] exp_uf = '0;

  always #5 clk = ~clk;

  tdm_chan_demux #(.NUM_CH(NC), .NUM_SLOTS(NS), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni, .rx_mask_i(rxm), .tx_mask_i(txm), .rev_i(rev), .framed_i(frm),
    .rx_start_i, .rx_strobe_i, .rx_data_i, .rx_valid_o, .rx_ch_o, .rx_data_o, .rx_framed_o,
    .tx_start_i, .tx_strobe_i, .tx_req_o, .tx_ch_o, .tx_avail_i, .tx_data_i,
    .tx_valid_o, .tx_data_o, .conflict_o, .underflow_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int owner(input logic [NC*NS-1:0] m, input int idx);
    if (idx >= NS) return -1;
    for (int c = 0; c < NC; c++) if (m[c*NS+idx]) return c;
    return -1;
  endfunction

  function automatic int nclaim(input logic [NC*NS-1:0] m, input int idx);
    int n = 0;
    if (idx >= NS) return 0;
    for (int c = 0; c < NC; c++) if (m[c*NS+idx]) n++;
    return n;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] d);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = d[7-i];
    return r;
  endfunction

  task automatic rx_slot(input bit st, input logic [7:0] d);
    int idx, own;
    logic [7:0] e;
    @(negedge clk);
    rx_start_i = st; rx_strobe_i = 1; rx_data_i = d;
    idx = st ? 0 : b_rx;
    own = owner(rxm, idx);
    if (nclaim(rxm, idx) > 1) exp_conf = 1;
    b_rx = (idx >= NS) ? NS : idx + 1;
    @(negedge clk);
    rx_start_i = 0; rx_strobe_i = 0;
    if (own < 0) begin
      chk(rx_valid_o == 0, "R4/R2 rx dropped", int'(rx_valid_o), 0);
    end else begin
      e = (rev[own] && !frm[own]) ? rev8(d) : d;
      chk(rx_valid_o == 1, "R3/R12 rx valid", int'(rx_valid_o), 1);
      chk(rx_ch_o == CW'(own), "R5/R2 rx channel", int'(rx_ch_o), own);
      chk(rx_data_o == e, "R7/R8 rx data", int'(rx_data_o), int'(e));
      chk(rx_framed_o == frm[own], "R8 rx tag", int'(rx_framed_o), int'(frm[own]));
    end
    chk(conflict_o == exp_conf, "R6 conflict", int'(conflict_o), int'(exp_conf));
  endtask

  task automatic tx_slot(input bit st, input bit avail);
    int idx, own;
    logic [7:0] src, e;
    @(negedge clk);
    idx = st ? 0 : b_tx;
    own = owner(txm, idx);
    if (nclaim(txm, idx) > 1) exp_conf = 1;
    b_tx = (idx >= NS) ? NS : idx + 1;
    src = (own < 0) ? 8'h00 : 8'(own * 37 + idx * 11 + 1);
    tx_start_i = st; tx_strobe_i = 1; tx_avail_i = avail; tx_data_i = src;
    #1;
    chk(tx_req_o == (own >= 0), "R9 tx request", int'(tx_req_o), int'(own >= 0));
    if (own >= 0) chk(tx_ch_o == CW'(own), "R9/R5 tx channel", int'(tx_ch_o), own);
    if (own < 0 || !avail) e = 8'hFF;
    else e = (rev[own] && !frm[own]) ? rev8(src) : src;
    if (own >= 0 && !avail) exp_uf[own] = 1'b1;
    @(negedge clk);
    tx_start_i = 0; tx_strobe_i = 0; tx_avail_i = 0;
    chk(tx_valid_o == 1, "R10 tx valid", int'(tx_valid_o), 1);
    chk(tx_data_o == e, "R10/R11/R7 tx data", int'(tx_data_o), int'(e));
    chk(underflow_o == exp_uf, "R11 underflow", int'(underflow_o), int'(exp_uf));
    chk(conflict_o == exp_conf, "R6 conflict", int'(conflict_o), int'(exp_conf));
  endtask

  task automatic set_cfg(input int k);
    for (int c = 0; c < NC; c++) begin
      logic [7:0] m;
      case (k)
        0: m = (c == 0) ? 8'hAA : (c == 1) ? 8'h55 : 8'h00;
        6: m = (c == 0) ? 8'h0F : (c == 2) ? 8'hF0 : (c == 3) ? 8'h81 : 8'h00;
        7: m = 8'h00;
        default: m = 8'(8'h03 << (2 * ((c + k) % NC)));
      endcase
      rxm[c*NS +: NS] = m;
      txm[c*NS +: NS] = (k == 0 || k >= 6) ? m : {m[6:0], m[7]};
    end
    rev = 4'(k * 5 + 2);
    frm = 4'(k * 3 + 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk(rx_valid_o == 0 && tx_valid_o == 0, "R1 reset valids", int'({rx_valid_o, tx_valid_o}), 0);
    chk(tx_data_o == 8'hFF, "R1 reset tx idle", int'(tx_data_o), 8'hFF);
    chk(conflict_o == 0 && underflow_o == 0, "R1 reset flags", int'({conflict_o, underflow_o}), 0);
    @(negedge clk); rst_ni = 1;

    for (int k = 0; k < 8; k++) begin
      @(negedge clk); set_cfg(k);
      for (int s = 0; s < NS + 2; s++) begin
        rx_slot(s == 0, 8'(s * 29 + k * 7 + 3));
        if (s % 3 == 1) @(negedge clk);  // gap must not advance the index
      end
      for (int s = 0; s < NS + 2; s++) begin
        tx_slot(s == 0, !(k >= 3 && s % 4 == 3));
        if (s % 3 == 2) @(negedge clk);
      end
    end

    // R12 mid-frame restart
    @(negedge clk); set_cfg(0);
    for (int s = 0; s < 3; s++) rx_slot(s == 0, 8'(s + 9));
    rx_slot(1, 8'hC3);
    rx_slot(0, 8'h3C);
    for (int s = 0; s < 5; s++) tx_slot(s == 0, 1);
    tx_slot(1, 1);
    tx_slot(0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule